// File: doc/BRIEF.md
# Command-Port DMA Channel Programmer

This block is the programming front-end of a multi-channel DMA controller. Software reaches it through one byte-wide host access path that addresses two ports: a command port and an execute port. A byte written to the command port names an operation in its upper four bits and a channel in its lower four bits. The execute-port bytes that follow carry the parameter of that operation one byte at a time, least significant byte first. A byte pointer, cleared by every command byte, tracks which byte comes next.

Each channel holds a 24-bit memory address, a 16-bit remaining count, a 16-bit I/O port address, an 8-bit mode and a mask bit. The transfer engine outside this block sees one armed flag per channel. It reads the registers of any channel through a view-select input and counts a channel down through a decrement strobe. The usual programming order for a channel is mask, mode, address, count, then unmask.

The host path uses a valid/ready handshake. `host_ready` is held high, so every access is taken in the cycle it is offered and the block never applies back-pressure. Each accepted read returns one response beat on the next cycle, and that beat cannot be stalled.

Top module: `dmacp_top`

## Requirements
- R1: After reset every channel is masked, its address, count, port and mode are zero, and no armed flag is set.
- R2: In a command byte, bits 7:4 are the opcode and bits 3:0 are the channel. Every command byte returns the execute byte pointer to byte 0, so a restarted sequence writes from its lowest byte.
- R3: Opcode 0x0 loads the channel's 16-bit I/O port address from two execute writes: bits 7:0 first, then bits 15:8.
- R4: Opcode 0x2 loads the 24-bit memory address from three execute writes in the order bits 7:0, 15:8, 23:16, and it touches only the named channel.
- R5: Opcode 0x4 loads the 16-bit count from two execute writes, low byte first. The value is stored as written (units minus one).
- R6: Opcode 0x7 loads the 8-bit mode from one execute write. Bit 2 enables a transfer, bit 3 selects read (clear means write), bit 0 selects an I/O-register target, and bit 6 selects 16-bit units.
- R7: Command opcode 0x9 masks the named channel and opcode 0xA unmasks it. The change is visible the cycle after the command is accepted.
- R8: `armed[n]` is high exactly when channel n is unmasked and its mode bit 2 is set.
- R9: With opcode 0x3 (address) or 0x5 (count) current, each execute read returns the next byte of that value, low byte first. `rsp_valid` and `rsp_data` appear one cycle after any accepted read. All other reads return 0x00.
- R10: Execute bytes beyond the length of the current parameter are ignored.
- R11: Opcodes 0x1, 0x6, 0x8, 0xB, 0xC, 0xE and 0xF are accepted. Neither they nor execute writes that follow them change any register.
- R12: Opcode 0xD (any channel nibble) masks every channel and zeroes every address, count, port and mode.
- R13: A `dec_valid` pulse lowers the named channel's count by one and leaves a count of zero at zero. A host count-byte write to the same channel in the same cycle takes priority over the pulse.
- R14: `host_ready` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access offered |
| host_ready | output | 1 | Access accepted (always high) |
| host_sel | input | 1 | 0 = command port, 1 = execute port |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response beat |
| rsp_data | output | 8 | Read response byte |
| dec_valid | input | 1 | Count decrement strobe from the engine |
| dec_ch | input | 4 | Channel to decrement |
| armed | output | NCH | Per-channel armed flags |
| view_ch | input | 4 | Channel shown on the view outputs |
| view_addr | output | 24 | Address of the viewed channel |
| view_count | output | 16 | Remaining count of the viewed channel |
| view_port | output | 16 | I/O port of the viewed channel |
| view_mode | output | 8 | Mode of the viewed channel |
| view_masked | output | 1 | Mask bit of the viewed channel |

## Verification
A command or execute write accepted at one clock edge changes the registers, the mask and the armed flags at that same edge. The view outputs and `armed` show the result at once, because they are combinational reads of the register state. A read response is registered, so it is due exactly one edge after the read is accepted. The bench drives each access on a falling edge and withdraws it on the next falling edge. It samples responses and register views at that second falling edge, which is one rising edge after the access. The collision case drives a decrement and a count write in the same cycle and checks the result one cycle later.

// File: rtl/dmacp_pkg.sv
package dmacp_pkg;
  typedef enum logic [3:0] {
    OP_PORT_WR = 4'h0,
    OP_ADDR_WR = 4'h2,
    OP_ADDR_RD = 4'h3,
    OP_CNT_WR  = 4'h4,
    OP_CNT_RD  = 4'h5,
    OP_MODE_WR = 4'h7,
    OP_MASK    = 4'h9,
    OP_UNMASK  = 4'hA,
    OP_CLEAR   = 4'hD
  } dmacp_op_e;

  localparam logic [3:0] OP_IDLE = 4'h1;
  localparam int MODE_XFER_BIT = 2;
endpackage

// File: rtl/dmacp_decode.sv
module dmacp_decode #(
  parameter int MAXB  = 3,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             exe_acc,
  input  logic [7:0]       wdata,
  output logic [3:0]       cur_op,
  output logic [3:0]       cur_ch,
  output logic [PTR_W-1:0] ptr,
  output logic             mask_set,
  output logic             mask_clr,
  output logic             clr_all,
  output logic [3:0]       pulse_ch
);
  import dmacp_pkg::*;

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(MAXB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_op <= OP_IDLE;
      cur_ch <= '0;
      ptr    <= '0;
    end else if (cmd_wr) begin
      cur_op <= wdata[7:4];
      cur_ch <= wdata[3:0];
      ptr    <= '0;
    end else if (exe_acc && ptr != PTR_END) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    mask_set = cmd_wr && (wdata[7:4] == OP_MASK);
    mask_clr = cmd_wr && (wdata[7:4] == OP_UNMASK);
    clr_all  = cmd_wr && (wdata[7:4] == OP_CLEAR);
    pulse_ch = wdata[3:0];
  end

  // R2: a command byte rewinds the pointer
  a_r2_ptr_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (ptr == '0));
  // R10: the pointer stops at the end of the longest parameter
  a_r10_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_acc && !cmd_wr && ptr == PTR_END) |=> (ptr == PTR_END));
endmodule

// File: rtl/dmacp_chan.sv
module dmacp_chan #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 16,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              exe_wr,
  input  logic [3:0]        op,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [7:0]        wdata,
  input  logic              dec,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  count,
  output logic [PORT_W-1:0] port,
  output logic [7:0]        mode,
  output logic              masked,
  output logic              armed
);
  import dmacp_pkg::*;

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_BYTES  = CNT_W / 8;
  localparam int PORT_BYTES = PORT_W / 8;

  logic wr_addr, wr_cnt, wr_port, wr_mode;

  always_comb begin
    wr_addr = exe_wr && (op == OP_ADDR_WR);
    wr_cnt  = exe_wr && (op == OP_CNT_WR) && (ptr < PTR_W'(CNT_BYTES));
    wr_port = exe_wr && (op == OP_PORT_WR);
    wr_mode = exe_wr && (op == OP_MODE_WR) && (ptr == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      addr   <= '0;
      count  <= '0;
      port   <= '0;
      mode   <= '0;
      masked <= 1'b1;
    end else begin
      if (mask_set) masked <= 1'b1;
      else if (mask_clr) masked <= 1'b0;

      if (wr_mode) mode <= wdata;

      for (int b = 0; b < ADDR_BYTES; b++)
        if (wr_addr && ptr == PTR_W'(b)) addr[8*b +: 8] <= wdata;

      for (int b = 0; b < PORT_BYTES; b++)
        if (wr_port && ptr == PTR_W'(b)) port[8*b +: 8] <= wdata;

      if (wr_cnt) begin
        for (int b = 0; b < CNT_BYTES; b++)
          if (ptr == PTR_W'(b)) count[8*b +: 8] <= wdata;
      end else if (dec && count != '0) begin
        count <= count - 1'b1;
      end
    end
  end

  assign armed = !masked && mode[MODE_XFER_BIT];

  // R12: master clear leaves the channel masked and empty
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (masked && addr == '0 && count == '0 && port == '0 && mode == '0));
  // R7: a mask command disarms the channel on the next cycle
  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set && !clr_all) |=> (masked && !armed));
  // R13: a decrement lowers a nonzero count by one
  a_r13_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && count != '0 && !wr_cnt && !clr_all) |=> (count == $past(count) - 1'b1));
  // R13: a count of zero stays at zero
  a_r13_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && count == '0 && !wr_cnt && !clr_all) |=> (count == '0));
endmodule

// File: rtl/dmacp_top.sv
module dmacp_top #(
  parameter int NCH    = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [7:0]        host_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  input  logic              dec_valid,
  input  logic [3:0]        dec_ch,
  output logic [NCH-1:0]    armed,
  input  logic [3:0]        view_ch,
  output logic [ADDR_W-1:0] view_addr,
  output logic [CNT_W-1:0]  view_count,
  output logic [PORT_W-1:0] view_port,
  output logic [7:0]        view_mode,
  output logic              view_masked
);
  import dmacp_pkg::*;

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_BYTES  = CNT_W / 8;
  localparam int MAXB       = ADDR_BYTES;
  localparam int PTR_W      = $clog2(MAXB + 1);

  logic             cmd_wr, exe_acc, exe_wr, exe_rd, rd_acc;
  logic [3:0]       cur_op, cur_ch, pulse_ch;
  logic [PTR_W-1:0] ptr;
  logic             mask_set, mask_clr, clr_all;

  logic [ADDR_W-1:0] ch_addr  [NCH];
  logic [CNT_W-1:0]  ch_count [NCH];
  logic [PORT_W-1:0] ch_port  [NCH];
  logic [7:0]        ch_mode  [NCH];
  logic [NCH-1:0]    ch_masked;

  assign host_ready = 1'b1;

  always_comb begin
    cmd_wr  = host_valid && !host_sel && host_we;
    exe_acc = host_valid && host_sel;
    exe_wr  = exe_acc && host_we;
    exe_rd  = exe_acc && !host_we;
    rd_acc  = host_valid && !host_we;
  end

  dmacp_decode #(.MAXB(MAXB), .PTR_W(PTR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .exe_acc(exe_acc),
    .wdata(host_wdata), .cur_op(cur_op), .cur_ch(cur_ch), .ptr(ptr),
    .mask_set(mask_set), .mask_clr(mask_clr), .clr_all(clr_all),
    .pulse_ch(pulse_ch)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmacp_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W), .PTR_W(PTR_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
      .mask_set(mask_set && pulse_ch == 4'(c)),
      .mask_clr(mask_clr && pulse_ch == 4'(c)),
      .exe_wr(exe_wr && cur_ch == 4'(c)),
      .op(cur_op), .ptr(ptr), .wdata(host_wdata),
      .dec(dec_valid && dec_ch == 4'(c)),
      .addr(ch_addr[c]), .count(ch_count[c]), .port(ch_port[c]),
      .mode(ch_mode[c]), .masked(ch_masked[c]), .armed(armed[c])
    );
  end

  always_comb begin
    view_addr   = '0;
    view_count  = '0;
    view_port   = '0;
    view_mode   = '0;
    view_masked = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (view_ch == 4'(c)) begin
        view_addr   = ch_addr[c];
        view_count  = ch_count[c];
        view_port   = ch_port[c];
        view_mode   = ch_mode[c];
        view_masked = ch_masked[c];
      end
    end
  end

  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = 8'h00;
    for (int c = 0; c < NCH; c++) begin
      if (cur_ch == 4'(c)) begin
        for (int b = 0; b < ADDR_BYTES; b++)
          if (cur_op == OP_ADDR_RD && ptr == PTR_W'(b)) rd_byte = ch_addr[c][8*b +: 8];
        for (int b = 0; b < CNT_BYTES; b++)
          if (cur_op == OP_CNT_RD && ptr == PTR_W'(b)) rd_byte = ch_count[c][8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_acc;
      rsp_data  <= exe_rd ? rd_byte : 8'h00;
    end
  end

  // R9: every accepted read gets exactly one response beat, one cycle later
  a_r9_rsp_due: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  a_r9_rsp_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);
  // R12: after a master clear no channel is armed
  a_r12_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (armed == '0));
  // R14: the host path never stalls
  a_r14_ready: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready);
endmodule

// File: tb/sim_dmacp_top.sv
`timescale 1ns/1ps
module sim_dmacp_top;
  localparam int NCH = 16;

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_sel = 0, host_we = 0;
  logic [7:0] host_wdata = 0;
  logic host_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic dec_valid = 0;
  logic [3:0] dec_ch = 0, view_ch = 0;
  logic [NCH-1:0] armed;
  logic [23:0] view_addr;
  logic [15:0] view_count, view_port;
  logic [7:0] view_mode;
  logic view_masked;

  int n_tests = 0, n_fail = 0;
  logic [7:0] rd_val;
  logic rd_ok;

  always #4 clk = ~clk;

  dmacp_top #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_sel(host_sel), .host_we(host_we), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dec_valid(dec_valid),
    .dec_ch(dec_ch), .armed(armed), .view_ch(view_ch), .view_addr(view_addr),
    .view_count(view_count), .view_port(view_port), .view_mode(view_mode),
    .view_masked(view_masked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_valid = 1; host_sel = sel; host_we = 1; host_wdata = d;
    @(negedge clk);
    host_valid = 0; host_we = 0;
  endtask

  task automatic hr(input logic sel);
    @(negedge clk);
    host_valid = 1; host_sel = sel; host_we = 0;
    @(negedge clk);
    host_valid = 0;
    rd_ok = rsp_valid; rd_val = rsp_data;
  endtask

  task automatic dec1(input logic [3:0] c);
    @(negedge clk);
    dec_valid = 1; dec_ch = c;
    @(negedge clk);
    dec_valid = 0;
  endtask

  task automatic view(input logic [3:0] c);
    view_ch = c; #1;
  endtask

  task automatic t_reset();
    view(4'd0);
    chk("R1 masked", view_masked, 1);
    chk("R1 regs", {view_addr, view_mode}, 0);
    chk("R1 count/port", {view_count, view_port}, 0);
    chk("R1 armed", armed, 0);
    chk("R14 ready", host_ready, 1);
  endtask

  task automatic t_program();
    hw(0, 8'h95); hw(0, 8'h75); hw(1, 8'h4D);
    hw(0, 8'h25); hw(1, 8'h11); hw(1, 8'h22); hw(1, 8'h33);
    hw(0, 8'h45); hw(1, 8'h0F); hw(1, 8'h00);
    view(4'd5);
    chk("R4 addr", view_addr, 24'h332211);
    chk("R5 count", view_count, 16'h000F);
    chk("R6 mode", view_mode, 8'h4D);
    chk("R6 bits xfer/read/io/16b", {view_mode[2], view_mode[3], view_mode[0], view_mode[6]}, 4'hF);
    chk("R8 masked not armed", armed[5], 0);
    hw(0, 8'hA5); view(4'd5);
    chk("R7 unmask", view_masked, 0);
    chk("R8 armed", armed, 32'h0020);
  endtask

  task automatic t_port_extra();
    hw(0, 8'h03); hw(1, 8'h34); hw(1, 8'h12); hw(1, 8'h99); hw(1, 8'h77);
    view(4'd3);
    chk("R3 port", view_port, 16'h1234);
    chk("R10 extra ignored", {view_addr, view_mode}, 0);
    chk("R10 extra count", view_count, 0);
  endtask

  task automatic t_readback();
    hw(0, 8'h35);
    hr(1); chk("R9 addr b0", {rd_ok, rd_val}, 9'h111);
    hr(1); chk("R9 addr b1", {rd_ok, rd_val}, 9'h122);
    hr(1); chk("R9 addr b2", {rd_ok, rd_val}, 9'h133);
    hr(1); chk("R9 past end", {rd_ok, rd_val}, 9'h100);
    hw(0, 8'h55);
    hr(1); chk("R9 count lo", {rd_ok, rd_val}, 9'h10F);
    hr(1); chk("R9 count hi", {rd_ok, rd_val}, 9'h100);
    hr(0); chk("R9 cmd port read", {rd_ok, rd_val}, 9'h100);
  endtask

  task automatic t_ptr_rewind();
    hw(0, 8'h26); hw(1, 8'h01); hw(0, 8'h26);
    hw(1, 8'hAA); hw(1, 8'hBB); hw(1, 8'hCC);
    view(4'd6); chk("R2 rewind", view_addr, 24'hCCBBAA);
    view(4'd5); chk("R4 other channel kept", view_addr, 24'h332211);
  endtask

  task automatic t_undef();
    hw(0, 8'h15); hw(1, 8'hAA); hw(1, 8'hBB);
    hw(0, 8'h85); hw(1, 8'hCC);
    hw(0, 8'hF5); hw(1, 8'hDD);
    hw(0, 8'hB5); hw(1, 8'hEE);
    view(4'd5);
    chk("R11 addr kept", view_addr, 24'h332211);
    chk("R11 count/port kept", {view_count, view_port}, 32'h000F0000);
    chk("R11 mode/mask kept", {view_mode, 7'd0, view_masked}, 16'h4D00);
    chk("R11 armed kept", armed, 32'h0020);
  endtask

  task automatic t_dec();
    hw(0, 8'h45); hw(1, 8'h02); hw(1, 8'h00);
    view(4'd5); chk("R5 count reload", view_count, 2);
    dec1(4'd5); view(4'd5); chk("R13 dec 2->1", view_count, 1);
    dec1(4'd6); view(4'd5); chk("R13 other channel dec", view_count, 1);
    dec1(4'd5); view(4'd5); chk("R13 dec 1->0", view_count, 0);
    dec1(4'd5); view(4'd5); chk("R13 floor at 0", view_count, 0);
    hw(0, 8'h55);
    hr(1); chk("R13 readback lo", rd_val, 0);
    hr(1); chk("R13 readback hi", rd_val, 0);
    hw(0, 8'h45);
    @(negedge clk);
    host_valid = 1; host_sel = 1; host_we = 1; host_wdata = 8'h07;
    dec_valid = 1; dec_ch = 4'd5;
    @(negedge clk);
    host_valid = 0; host_we = 0; dec_valid = 0;
    view(4'd5); chk("R13 write beats dec", view_count, 7);
  endtask

  task automatic t_arm_mode();
    hw(0, 8'h75); hw(1, 8'h48);
    view(4'd5);
    chk("R8 no xfer bit", armed[5], 0);
    chk("R8 still unmasked", view_masked, 0);
    hw(1, 8'h4C);
    view(4'd5); chk("R10 mode extra ignored", view_mode, 8'h48);
    hw(0, 8'h75); hw(1, 8'h04);
    chk("R8 rearmed", armed[5], 1);
    hw(0, 8'h95);
    chk("R7 mask disarms", armed[5], 0);
  endtask

  task automatic t_clear();
    hw(0, 8'hA5); hw(0, 8'hD7);
    chk("R12 armed", armed, 0);
    for (int c = 3; c <= 6; c++) begin
      view(4'(c));
      chk("R12 masked", view_masked, 1);
      chk("R12 addr/mode", {view_addr, view_mode}, 0);
      chk("R12 count/port", {view_count, view_port}, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program();
    t_port_extra();
    t_readback();
    t_ptr_rewind();
    t_undef();
    t_dec();
    t_arm_mode();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule